// File: doc/BRIEF.md
# Two-Level Prioritized Interrupt Controller

This block sits between a small microcontroller core and its interrupt-raising peripherals. Each peripheral presents a pending flag. The controller masks each flag with a per-source enable bit and a global enable bit. It sorts the surviving flags into two programmable levels and picks one winner by a fixed slot order. It then raises a registered request line together with the vector address of the winning slot.

The core answers with an acknowledge pulse when it branches to the handler and with a return pulse when the handler finishes. A two-bit in-service record tracks the nesting depth. A handler running at the low level can be interrupted by a high-level source. A handler running at the high level cannot be interrupted at all. Sources that the integration marks as self-clearing receive a one-cycle clear strobe at acknowledge. All other flags must be cleared by the handler. A flag still set when the handler returns therefore triggers service again.

Configuration is loaded through two write strobes, one for the enable set and one for the level set. Address decoding is left to the surrounding bus logic.

Top module: `prio_irq_ctrl`

## Requirements
- R1: Source bit i (slot i, 0 to 21) has the 16-bit vector 8*i+3, so slot 0 gives 0x0003 and slot 21 gives 0x00AB.
- R2: A source can raise a request only while its enable bit and the global enable bit are both 1. Otherwise its pending flag has no effect: the request stays low and no clear strobe is issued.
- R3: After reset, every enable bit, the global enable and every level bit are 0. The request output and all clear strobes are low, and pending flags raise nothing.
- R4: Among eligible sources, any source whose level bit is 1 (high) beats every level-0 (low) source. Within one level, the lowest slot number wins.
- R5: While a low-level handler is in service, only a high-level winner may raise a request. While a high-level handler is in service, no request is raised.
- R6: A request blocked by R5 stays pending. It is arbitrated again once the blocking handler returns.
- R7: If the flag of a serviced source is still set when its return pulse is sampled, the request rises again on the next clock edge.
- R8: In the cycle in which acknowledge is asserted while the request is high, clr_o pulses the bit of the granted slot if that slot's AUTO_CLR bit is 1, and stays zero otherwise. Acknowledge while the request is low has no effect.
- R9: The request and vector are registered. A pending flag that is eligible at one clock edge shows on the outputs after that edge. Once raised, the request and vector hold unchanged, even if a better source appears, until acknowledge is sampled. The request is low after that edge.
- R10: A return pulse clears the high-level in-service bit if it is set, and clears the low-level bit otherwise. A low-level handler interrupted by a high-level one therefore stays in service after the high-level return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pend_i | input | N_SRC | Pending flag per source slot |
| cfg_mask_we | input | 1 | Load enable set and global enable |
| cfg_en_d | input | N_SRC | Per-source enable data |
| cfg_gen_d | input | 1 | Global enable data |
| cfg_lvl_we | input | 1 | Load level set |
| cfg_lvl_d | input | N_SRC | Per-source level data (1 = high) |
| ack_i | input | 1 | Core has branched to the requested handler |
| ret_i | input | 1 | Core has finished the current handler |
| irq_req_o | output | 1 | Registered interrupt request |
| irq_vec_o | output | 16 | Registered vector address of the request |
| clr_o | output | N_SRC | Hardware clear strobe per source |

## Verification
The properties assume that the core sends acknowledge only while the request is high and never in the same cycle as a return. They also assume that a return follows only a handler that was acknowledged, and that pending flags change only between clock edges. The bench keeps to these rules. It pulses acknowledge only after it has seen the request high, issues exactly one return per handler, and drives every input on the falling edge. Like a peripheral, it drops a flag after acknowledge unless the scenario under test deliberately leaves it set to provoke re-entry.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  localparam int unsigned VEC_W      = 16;
  localparam int unsigned VEC_STRIDE = 8;
  localparam int unsigned VEC_OFS    = 3;

  typedef enum logic {
    LVL_LOW  = 1'b0,
    LVL_HIGH = 1'b1
  } irq_lvl_e;

  // Handler entry address of a slot.
  function automatic logic [VEC_W-1:0] slot_vector(input int unsigned slot);
    return VEC_W'(slot * VEC_STRIDE + VEC_OFS);
  endfunction
endpackage

// File: rtl/irq_mask_split.sv
module irq_mask_split #(
  parameter int N = 22
) (
  input  logic [N-1:0] pend_i,
  input  logic [N-1:0] en_i,
  input  logic         gen_i,
  input  logic [N-1:0] lvl_i,
  output logic [N-1:0] hi_o,
  output logic [N-1:0] lo_o
);
  logic [N-1:0] elig;

  // A flag counts only when both its own and the global enable are set.
  assign elig = pend_i & en_i & {N{gen_i}};
  assign hi_o = elig & lvl_i;
  assign lo_o = elig & ~lvl_i;
endmodule

// File: rtl/irq_fixed_pick.sv
module irq_fixed_pick #(
  parameter int N  = 22,
  parameter int IW = 5
) (
  input  logic [N-1:0]  req_i,
  output logic          found_o,
  output logic [IW-1:0] idx_o
);
  // Lowest set bit wins: scan downward so the last hit is the smallest slot.
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        found_o = 1'b1;
        idx_o   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/irq_nest_track.sv
module irq_nest_track (
  input  logic clk,
  input  logic rst_n,
  input  logic ack_i,
  input  logic ack_hi_i,
  input  logic ret_i,
  output logic lo_q_o,
  output logic hi_q_o
);
  logic lo_n, hi_n;

  always_comb begin
    lo_n = lo_q_o;
    hi_n = hi_q_o;
    if (ret_i) begin
      if (hi_q_o) hi_n = 1'b0;
      else        lo_n = 1'b0;
    end
    if (ack_i) begin
      if (ack_hi_i) hi_n = 1'b1;
      else          lo_n = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_q_o <= 1'b0;
      hi_q_o <= 1'b0;
    end else begin
      lo_q_o <= lo_n;
      hi_q_o <= hi_n;
    end
  end

  // R10
  ret_keep_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_i && hi_q_o && lo_q_o) |=> lo_q_o);
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import prio_irq_pkg::*;
#(
  parameter int               N_SRC    = 22,
  parameter logic [N_SRC-1:0] AUTO_CLR = N_SRC'(10)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] pend_i,
  input  logic             cfg_mask_we,
  input  logic [N_SRC-1:0] cfg_en_d,
  input  logic             cfg_gen_d,
  input  logic             cfg_lvl_we,
  input  logic [N_SRC-1:0] cfg_lvl_d,
  input  logic             ack_i,
  input  logic             ret_i,
  output logic             irq_req_o,
  output logic [15:0]      irq_vec_o,
  output logic [N_SRC-1:0] clr_o
);
  localparam int IW = (N_SRC > 1) ? $clog2(N_SRC) : 1;
  localparam logic [N_SRC-1:0] ONE = N_SRC'(1);

  // configuration registers
  logic [N_SRC-1:0] en_q, lvl_cfg_q;
  logic             gen_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q      <= '0;
      gen_q     <= 1'b0;
      lvl_cfg_q <= '0;
    end else begin
      if (cfg_mask_we) begin
        en_q  <= cfg_en_d;
        gen_q <= cfg_gen_d;
      end
      if (cfg_lvl_we) lvl_cfg_q <= cfg_lvl_d;
    end
  end

  // level split and per-level fixed-order pick
  logic [1:0][N_SRC-1:0] lvl_req;
  logic [1:0]            lvl_found;
  logic [1:0][IW-1:0]    lvl_idx;

  irq_mask_split #(.N(N_SRC)) u_split (
    .pend_i (pend_i),
    .en_i   (en_q),
    .gen_i  (gen_q),
    .lvl_i  (lvl_cfg_q),
    .hi_o   (lvl_req[1]),
    .lo_o   (lvl_req[0])
  );

  for (genvar g = 0; g < 2; g++) begin : g_pick
    irq_fixed_pick #(.N(N_SRC), .IW(IW)) u_pick (
      .req_i   (lvl_req[g]),
      .found_o (lvl_found[g]),
      .idx_o   (lvl_idx[g])
    );
  end

  // winner and in-service gating
  logic     insvc_lo, insvc_hi;
  logic     win_any, grant_ok, ack_fire;
  irq_lvl_e win_lvl;
  logic [IW-1:0] win_idx;

  assign win_any  = |lvl_found;
  assign win_lvl  = lvl_found[1] ? LVL_HIGH : LVL_LOW;
  assign win_idx  = lvl_found[1] ? lvl_idx[1] : lvl_idx[0];
  assign grant_ok = win_any && !insvc_hi && (!insvc_lo || win_lvl == LVL_HIGH);

  // registered request, held until acknowledged
  logic          req_r;
  logic [15:0]   vec_r;
  logic [IW-1:0] idx_r;
  irq_lvl_e      lvl_r;

  assign ack_fire = ack_i && req_r;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_r <= 1'b0;
      vec_r <= '0;
      idx_r <= '0;
      lvl_r <= LVL_LOW;
    end else if (req_r) begin
      if (ack_i) req_r <= 1'b0;
    end else if (grant_ok) begin
      req_r <= 1'b1;
      vec_r <= slot_vector(int'(win_idx));
      idx_r <= win_idx;
      lvl_r <= win_lvl;
    end
  end

  irq_nest_track u_nest (
    .clk      (clk),
    .rst_n    (rst_n),
    .ack_i    (ack_fire),
    .ack_hi_i (lvl_r == LVL_HIGH),
    .ret_i    (ret_i),
    .lo_q_o   (insvc_lo),
    .hi_q_o   (insvc_hi)
  );

  for (genvar s = 0; s < N_SRC; s++) begin : g_clr
    assign clr_o[s] = AUTO_CLR[s] && ack_fire && (idx_r == IW'(s));
  end

  assign irq_req_o = req_r;
  assign irq_vec_o = vec_r;

  // R1
  vec_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_r |-> (vec_r[2:0] == 3'd3) && (vec_r <= slot_vector(N_SRC - 1)));

  // R9
  vec_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_r && !ack_i) |=> (req_r && $stable(vec_r)));

  // R2
  mask_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_r) |-> $past(gen_q));

  // R5
  hi_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_r && insvc_hi) |=> !req_r);

  // R5
  preempt_lvl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(req_r) && insvc_lo) |-> (lvl_r == LVL_HIGH));

  // R4
  level_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(req_r) && lvl_r == LVL_LOW) |-> ($past(lvl_req[1]) == '0));

  // R4
  pick_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_found[1] |-> (lvl_req[1][lvl_idx[1]] &&
                      ((lvl_req[1] & ((ONE << lvl_idx[1]) - ONE)) == '0)));

  // R8
  clr_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|clr_o) |=> !req_r);
endmodule

// File: tb/sim_prio_irq_ctrl.sv
module sim_prio_irq_ctrl;
  localparam int N = 22;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] pend_i = '0;
  logic         cfg_mask_we = 1'b0, cfg_gen_d = 1'b0, cfg_lvl_we = 1'b0;
  logic [N-1:0] cfg_en_d = '0, cfg_lvl_d = '0;
  logic         ack_i = 1'b0, ret_i = 1'b0;
  logic         irq_req_o;
  logic [15:0]  irq_vec_o;
  logic [N-1:0] clr_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  prio_irq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .pend_i(pend_i),
    .cfg_mask_we(cfg_mask_we), .cfg_en_d(cfg_en_d), .cfg_gen_d(cfg_gen_d),
    .cfg_lvl_we(cfg_lvl_we), .cfg_lvl_d(cfg_lvl_d),
    .ack_i(ack_i), .ret_i(ret_i),
    .irq_req_o(irq_req_o), .irq_vec_o(irq_vec_o), .clr_o(clr_o)
  );

  function automatic logic [31:0] vec_of(input int slot);
    return 32'(slot * 8 + 3);
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cfg(input logic [N-1:0] en, input logic g, input logic [N-1:0] lv);
    cfg_mask_we = 1'b1; cfg_en_d = en; cfg_gen_d = g;
    cfg_lvl_we  = 1'b1; cfg_lvl_d = lv;
    step(1);
    cfg_mask_we = 1'b0; cfg_lvl_we = 1'b0;
  endtask

  task automatic do_ack(output logic [N-1:0] seen);
    ack_i = 1'b1;
    #1 seen = clr_o;
    step(1);
    ack_i = 1'b0;
  endtask

  task automatic do_ret();
    ret_i = 1'b1;
    step(1);
    ret_i = 1'b0;
  endtask

  task automatic quiesce();
    logic [N-1:0] c;
    pend_i = '0;
    step(1);
    if (irq_req_o) do_ack(c);
    do_ret();
    do_ret();
    step(2);
  endtask

  task automatic t_reset();
    check("R3 request after reset", irq_req_o, 0);
    check("R3 clear after reset", clr_o, 0);
    pend_i = '1;
    step(3);
    check("R3 all masked after reset", irq_req_o, 0);
    pend_i = '0;
    step(1);
  endtask

  task automatic t_mask();
    logic [N-1:0] c;
    cfg(N'(1) << 5, 1'b0, '0);
    pend_i[5] = 1'b1;
    step(3);
    check("R2 global off blocks", irq_req_o, 0);
    check("R2 no clear while masked", clr_o, 0);
    cfg('0, 1'b1, '0);
    step(3);
    check("R2 source off blocks", irq_req_o, 0);
    cfg(N'(1) << 5, 1'b1, '0);
    step(1);
    check("R2 both on request", irq_req_o, 1);
    check("R2 both on vector", irq_vec_o, vec_of(5));
    do_ack(c);
    quiesce();
  endtask

  task automatic t_timing();
    logic [N-1:0] c;
    cfg('1, 1'b1, '0);
    pend_i[9] = 1'b1;
    #1 check("R9 not yet registered", irq_req_o, 0);
    step(1);
    check("R9 request one edge later", irq_req_o, 1);
    check("R9 vector slot 9", irq_vec_o, vec_of(9));
    pend_i[2] = 1'b1;
    step(3);
    check("R9 vector held", irq_vec_o, vec_of(9));
    check("R9 request held", irq_req_o, 1);
    check("R8 no clear without ack", clr_o, 0);
    do_ack(c);
    pend_i[9] = 1'b0;
    check("R9 request low after ack", irq_req_o, 0);
    do_ret();
    step(1);
    check("R9 next winner vector", irq_vec_o, vec_of(2));
    do_ack(c);
    quiesce();
  endtask

  task automatic t_vec();
    logic [N-1:0] c;
    pend_i[0] = 1'b1;
    step(1);
    check("R1 slot 0 vector", irq_vec_o, 32'h0003);
    do_ack(c);
    pend_i[0] = 1'b0;
    do_ret();
    step(1);
    pend_i[21] = 1'b1;
    step(1);
    check("R1 slot 21 vector", irq_vec_o, 32'h00AB);
    do_ack(c);
    quiesce();
  endtask

  task automatic t_arb();
    logic [N-1:0] c;
    pend_i = (N'(1) << 3) | (N'(1) << 7) | (N'(1) << 12);
    step(1);
    check("R4 lowest slot same level", irq_vec_o, vec_of(3));
    do_ack(c); pend_i[3] = 1'b0; do_ret();
    step(1);
    check("R4 next slot same level", irq_vec_o, vec_of(7));
    do_ack(c);
    quiesce();
    cfg('1, 1'b1, N'(1) << 12);
    pend_i = (N'(1) << 3) | (N'(1) << 7) | (N'(1) << 12);
    step(1);
    check("R4 high level beats lower slot", irq_vec_o, vec_of(12));
    do_ack(c); pend_i[12] = 1'b0; do_ret();
    step(1);
    check("R4 low level after high served", irq_vec_o, vec_of(3));
    do_ack(c);
    quiesce();
  endtask

  task automatic t_nest();
    logic [N-1:0] c;
    cfg('1, 1'b1, (N'(1) << 15) | N'(1));
    pend_i[4] = 1'b1;
    step(1);
    check("R5 low handler vector", irq_vec_o, vec_of(4));
    do_ack(c); pend_i[4] = 1'b0;
    pend_i[2] = 1'b1;
    step(3);
    check("R6 same level held", irq_req_o, 0);
    pend_i[15] = 1'b1;
    step(1);
    check("R5 high preempts low", irq_req_o, 1);
    check("R5 preempt vector", irq_vec_o, vec_of(15));
    do_ack(c); pend_i[15] = 1'b0;
    pend_i[0] = 1'b1;
    step(3);
    check("R5 high handler blocks high", irq_req_o, 0);
    do_ret();
    step(1);
    check("R10 high cleared first", irq_vec_o, vec_of(0));
    check("R10 high cleared request", irq_req_o, 1);
    do_ack(c); pend_i[0] = 1'b0;
    do_ret();
    step(3);
    check("R10 low still in service", irq_req_o, 0);
    do_ret();
    step(1);
    check("R6 held request after return", irq_vec_o, vec_of(2));
    do_ack(c);
    quiesce();
  endtask

  task automatic t_reentry();
    logic [N-1:0] c;
    cfg('1, 1'b1, '0);
    pend_i[6] = 1'b1;
    step(1);
    check("R7 first entry", irq_vec_o, vec_of(6));
    do_ack(c);
    check("R8 no clear for manual slot", c, 0);
    do_ret();
    check("R7 not before next edge", irq_req_o, 0);
    step(1);
    check("R7 re-entry request", irq_req_o, 1);
    check("R7 re-entry vector", irq_vec_o, vec_of(6));
    do_ack(c);
    quiesce();
  endtask

  task automatic t_autoclr();
    logic [N-1:0] c;
    do_ack(c);
    check("R8 ack without request", c, 0);
    check("R8 ack without request keeps idle", irq_req_o, 0);
    pend_i[1] = 1'b1;
    step(1);
    check("R8 slot 1 request", irq_req_o, 1);
    do_ack(c);
    check("R8 auto clear strobe", c, N'(1) << 1);
    quiesce();
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    t_reset();
    t_mask();
    t_timing();
    t_vec();
    t_arb();
    t_nest();
    t_reentry();
    t_autoclr();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule